// File: doc/BRIEF.md
# Per-Channel Zero-Run Detector

This block watches a group of audio lanes that deliver one sample each per sample period and reports, per lane, when that lane has carried nothing but zero samples for a long unbroken run. Each lane keeps its own saturating run counter. The counter moves only when the sample strobe is high. One nonzero sample on a lane restarts that lane's run.

A combined flag reports that every lane is in the zero state at the same time. One polarity input sets the active level of all flags together. The detector looks at each lane's own incoming data. Any copying of one lane's data onto other lanes happens downstream and has no effect on the flags. Pairing lanes into stereo indications is left to gating outside the block.

Top module: `zero_watch`

## Requirements
- R1: While and after a synchronous reset (`rst` high at a clock edge), every run count is zero and all seven flags are inactive.
- R2: A lane's flag becomes active on the clock edge that accepts its 1024th consecutive all-zero sample, and not earlier: after 1023 such samples it is still inactive.
- R3: Further zero samples keep an active flag active. The run count saturates and never wraps, even after thousands of zero samples.
- R4: A sample with any nonzero bit on a lane makes that lane's flag inactive from the edge that accepts it. A new run of 1024 zero samples is then needed to make it active again.
- R5: Run counts advance only on clock edges where `sampleValid` is high. Idle cycles, however many, neither advance nor clear a run.
- R6: `allFlag` is active exactly when all six lane flags are active.
- R7: With `activeLow` = 0 an active flag reads 1. With `activeLow` = 1 an active flag reads 0 and an inactive flag reads 1. The setting applies at once to all seven outputs and does not disturb any run count.
- R8: Lane i occupies bits [24*i+23 : 24*i] of `sampleData`, with lane 0 at the least significant end, and drives `chanFlag[i]`. Every bit of the lane counts toward "nonzero". A lane's flag depends only on its own lane's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Strobe: one sample per lane is present this cycle |
| sampleData | input | 144 | Six 24-bit lane samples, lane 0 in the low bits |
| activeLow | input | 1 | Flag polarity select: 0 active high, 1 active low |
| chanFlag | output | 6 | Per-lane zero-run flags |
| allFlag | output | 1 | Active when every lane is in the zero state |

## Verification
On every cycle the assertions check four things, all in polarity-neutral form: a nonzero lane sample clears that lane's flag, a flag only rises right after a zero sample was accepted, idle cycles leave the flag state unchanged, and the combined flag agrees with the six lane flags. A counter-based window check on lane 0 compares the exact 1024-sample activation point against a reference count. Some behaviour can only be shown by the directed scenarios. These cover the off-by-one boundary at 1023 and 1024 samples, saturation over long runs, the lane-to-bit mapping including the top bit of the last lane, and polarity flips applied while runs are held.

// File: rtl/zero_watch_pkg.sv
package zero_watch_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic advance;   // accept the samples present this cycle
    logic restart;   // clear every run count
  } zwStrobe_t;
endpackage

// File: rtl/zero_watch_ctrl.sv
module zero_watch_ctrl
  import zero_watch_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              rst,
  input  logic              sampleValid,
  input  logic              activeLow,
  input  logic [NUM_CH-1:0] zeroState,
  output zwStrobe_t         strobe,
  output logic [NUM_CH-1:0] chanFlag,
  output logic              allFlag
);
  logic allZero;

  always_comb begin
    strobe.restart = rst;
    strobe.advance = sampleValid & ~rst;
  end

  assign allZero  = &zeroState;
  assign chanFlag = zeroState ^ {NUM_CH{activeLow}};
  assign allFlag  = allZero ^ activeLow;
endmodule

// File: rtl/zero_watch_dp.sv
module zero_watch_dp
  import zero_watch_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                       clk,
  input  zwStrobe_t                  strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  output logic [NUM_CH-1:0]          zeroState
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic [CNT_W-1:0] runCnt;
    logic             laneZero;

    assign laneZero = (sampleData[g*SAMPLE_W +: SAMPLE_W] == '0);

    always_ff @(posedge clk) begin
      if (strobe.restart) begin
        runCnt <= '0;
      end else if (strobe.advance) begin
        if (!laneZero)
          runCnt <= '0;
        else if (runCnt != CNT_MAX)
          runCnt <= runCnt + 1'b1;
      end
    end

    assign zeroState[g] = (runCnt == CNT_MAX);
  end
endmodule

// File: rtl/zero_watch.sv
module zero_watch
  import zero_watch_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input  logic                       activeLow,
  output logic [NUM_CH-1:0]          chanFlag,
  output logic                       allFlag
);
  zwStrobe_t         strobe;
  logic [NUM_CH-1:0] zeroState;

  zero_watch_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .rst        (rst),
    .sampleValid(sampleValid),
    .activeLow  (activeLow),
    .zeroState  (zeroState),
    .strobe     (strobe),
    .chanFlag   (chanFlag),
    .allFlag    (allFlag)
  );

  zero_watch_dp #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .sampleData(sampleData),
    .zeroState (zeroState)
  );
endmodule

// File: rtl/zero_watch_chk.sv
module zero_watch_chk #(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sampleValid,
  input logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input logic                       activeLow,
  input logic [NUM_CH-1:0]          chanFlag,
  input logic                       allFlag
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [NUM_CH-1:0] rawFlag;
  logic              rawAll;
  logic [CNT_W-1:0]  refCnt;

  assign rawFlag = chanFlag ^ {NUM_CH{activeLow}};
  assign rawAll  = allFlag ^ activeLow;

  // Reference run length for lane 0, used for the window check
  always_ff @(posedge clk) begin
    if (rst)
      refCnt <= '0;
    else if (sampleValid) begin
      if (sampleData[SAMPLE_W-1:0] != '0)
        refCnt <= '0;
      else if (refCnt != CNT_W'(RUN_LEN))
        refCnt <= refCnt + 1'b1;
    end
  end

  assert_run_window_R2: assert property (@(posedge clk) disable iff (rst)
    rawFlag[0] == (refCnt == CNT_W'(RUN_LEN)));

  assert_global_and_R6: assert property (@(posedge clk) disable iff (rst)
    rawAll == (&rawFlag));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> rawFlag == $past(rawFlag));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assert_clear_on_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
      (sampleValid && sampleData[g*SAMPLE_W +: SAMPLE_W] != '0) |=> !rawFlag[g]);

    assert_rise_after_zero_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(rawFlag[g]) |-> ($past(sampleValid) && $past(sampleData[g*SAMPLE_W +: SAMPLE_W]) == '0));
  end
endmodule

bind zero_watch zero_watch_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleData(sampleData),
  .activeLow(activeLow), .chanFlag(chanFlag), .allFlag(allFlag)
);

// File: tb/zero_watch_tb.sv
module zero_watch_tb;
  localparam int NUM_CH = 6;
  localparam int SW     = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sampleValid = 1'b0;
  logic [NUM_CH*SW-1:0] sampleData = '0;
  logic              activeLow = 1'b0;
  logic [NUM_CH-1:0] chanFlag;
  logic              allFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  zero_watch u_dut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleData(sampleData),
    .activeLow(activeLow), .chanFlag(chanFlag), .allFlag(allFlag)
  );

  task automatic checkVal(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One strobe on a negedge, returns at the following negedge
  task automatic sendSample(input logic [NUM_CH*SW-1:0] d);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = d;
    @(negedge clk);
    sampleValid = 1'b0;
    sampleData  = '0;
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendSample('0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    checkVal("R1 lane flags after reset", {2'b0, chanFlag}, 8'h00);
    checkVal("R1 all flag after reset", {7'b0, allFlag}, 8'h00);
  endtask

  task automatic testBoundary();
    doReset();
    sendZeros(1023);
    checkVal("R2 flags after 1023 zeros", {2'b0, chanFlag}, 8'h00);
    checkVal("R6 all flag after 1023 zeros", {7'b0, allFlag}, 8'h00);
    sendZeros(1);
    checkVal("R2 flags after 1024 zeros", {2'b0, chanFlag}, 8'h3f);
    checkVal("R6 all flag after 1024 zeros", {7'b0, allFlag}, 8'h01);
    sendZeros(2100);
    checkVal("R3 flags held after long run", {2'b0, chanFlag}, 8'h3f);
  endtask

  task automatic testPolarity();
    // runs still saturated from previous scenario
    @(negedge clk);
    activeLow = 1'b1;
    #1;
    checkVal("R7 active-low lane flags", {2'b0, chanFlag}, 8'h00);
    checkVal("R7 active-low all flag", {7'b0, allFlag}, 8'h00);
    @(negedge clk);
    activeLow = 1'b0;
    #1;
    checkVal("R7 back to active-high keeps runs", {2'b0, chanFlag}, 8'h3f);
  endtask

  task automatic testClear();
    logic [NUM_CH*SW-1:0] d;
    d = '0;
    d[2*SW + 5] = 1'b1;
    sendSample(d);
    checkVal("R4 lane 2 cleared", {2'b0, chanFlag}, 8'h3b);
    checkVal("R6 all flag drops", {7'b0, allFlag}, 8'h00);
    sendZeros(1023);
    checkVal("R4 lane 2 needs full run again", {2'b0, chanFlag}, 8'h3b);
    sendZeros(1);
    checkVal("R4 lane 2 active after new run", {2'b0, chanFlag}, 8'h3f);
    d = '0;
    d[NUM_CH*SW-1] = 1'b1;
    sendSample(d);
    checkVal("R8 top bit of lane 5 clears lane 5", {2'b0, chanFlag}, 8'h1f);
  endtask

  task automatic testIdle();
    doReset();
    sendZeros(1000);
    repeat (5000) @(negedge clk);
    checkVal("R5 idle cycles do not count", {2'b0, chanFlag}, 8'h00);
    sendZeros(23);
    checkVal("R5 idle cycles do not clear (1023)", {2'b0, chanFlag}, 8'h00);
    sendZeros(1);
    checkVal("R5 run completes across idle gap", {2'b0, chanFlag}, 8'h3f);
  endtask

  task automatic testIndependence();
    logic [NUM_CH*SW-1:0] d;
    doReset();
    d = '0;
    d[0] = 1'b1;
    for (int i = 0; i < 1024; i++) sendSample(d);
    checkVal("R8 only lane 0 kept busy", {2'b0, chanFlag}, 8'h3e);
    checkVal("R6 all flag needs every lane", {7'b0, allFlag}, 8'h00);
    @(negedge clk);
    activeLow = 1'b1;
    #1;
    checkVal("R7 active-low mixed flags", {2'b0, chanFlag}, 8'h01);
    checkVal("R7 active-low all flag inactive", {7'b0, allFlag}, 8'h01);
    @(negedge clk);
    activeLow = 1'b0;
  endtask

  initial begin
    testReset();
    testBoundary();
    testPolarity();
    testClear();
    testIdle();
    testIndependence();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule